// File: doc/BRIEF.md
# Real-Time Clock Prescaler and Periodic Rate Generator

This block turns a 32768 Hz time base, delivered as a one-cycle enable in the system clock domain, into two timing outputs. The first is a once-per-second update strobe that drives the seconds counter of a calendar. The second is a sticky periodic interrupt flag whose rate is chosen by a 4-bit rate code. A 15-bit prescaler counts the time-base ticks. The update strobe marks its wrap, and the periodic flag is raised each time a selectable group of its low bits rolls over.

Software programs the block through one 7-bit control byte. Bits 6 to 4 hold the divider mode and bits 3 to 0 hold the rate code. Mode 010 runs the chain. Mode 111 holds the chain at its half-second point, so releasing it to 010 places the next update exactly half a second later. Every other mode freezes the chain where it stands. Reading the status clears the periodic flag.

Top module: `rtc_tickgen`

## Requirements
- R1: Synchronous reset loads the control byte to 0x26 (mode 010, rate 0110), clears both outputs and places the chain at its half-second point, so the first update strobe follows 16384 ticks after reset.
- R2: A write with `wr_en` loads `wr_data` into the control byte, and `ctrl_q` shows it from the next cycle on; bits 6 to 4 are the divider mode and bits 3 to 0 the rate code.
- R3: In mode 010 the update strobe is a one-cycle pulse repeated every 32768 counted ticks.
- R4: Mode 111 produces no strobe and no periodic event; after a write to mode 010 the first strobe follows the 16384th counted tick.
- R5: Any mode other than 010 and 111 freezes the chain without resetting it, and counting resumes from the frozen position when mode 010 returns.
- R6: Rate code 0000 never sets the periodic flag.
- R7: Rate codes 3 to 15 set the flag every 2^(code-1) ticks (code 3 is 4 ticks, or 8192 Hz; code 6 is 32 ticks; code 15 is 16384 ticks, or 2 Hz), with the first event 2^(code-1) ticks after release from mode 111.
- R8: Rate codes 1 and 2 give the periods of codes 8 and 9, which are 128 and 256 ticks.
- R9: The periodic flag stays set until a cycle with `stat_rd` high. If a new event falls in that same cycle, the flag stays set.
- R10: The chain advances only on cycles with `tick_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz rate |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 7 | Control byte: [6:4] divider mode, [3:0] rate code |
| stat_rd | input | 1 | Status read, clears the periodic flag |
| ctrl_q | output | 7 | Control byte readback |
| upd_stb | output | 1 | One-cycle 1 Hz update strobe |
| pi_flag | output | 1 | Sticky periodic interrupt flag |

## Verification
Every result is registered. A tick counted at a clock edge therefore shows its strobe or flag in the cycle after that edge, and a write or a status read shows its effect one cycle after the edge that takes it. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the edge that released the chain, so the first strobe is expected at count 16384, or 32767 when ticks come every other cycle, and the first periodic flag is expected at count 2^(code-1). Flag clearing is placed on known edges: one edge carries no event and one carries a new event. This checks both outcomes of a status read.

// File: rtl/rtc_tickgen_pkg.sv
package rtc_tickgen_pkg;
  localparam logic [2:0] MODE_RUN  = 3'b010;
  localparam logic [2:0] MODE_HOLD = 3'b111;

  // Prescaler bit count whose rollover defines the periodic rate; 0 = off.
  function automatic int rate_shift(input logic [3:0] code);
    case (code)
      4'd0:    rate_shift = 0;
      4'd1:    rate_shift = 7;
      4'd2:    rate_shift = 8;
      default: rate_shift = int'(code) - 1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg #(
  parameter int SEL_W  = 3,
  parameter int RATE_W = 4,
  parameter logic [SEL_W-1:0]  RST_SEL  = 3'b010,
  parameter logic [RATE_W-1:0] RST_RATE = 4'b0110,
  localparam int CTRL_W = SEL_W + RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [SEL_W-1:0]  sel,
  output logic [RATE_W-1:0] rate
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel  <= RST_SEL;
      rate <= RST_RATE;
    end else if (wr_en) begin
      sel  <= wr_data[CTRL_W-1:RATE_W];
      rate <= wr_data[RATE_W-1:0];
    end
  end

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ({sel, rate} == $past(wr_data)));
endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_tickgen_pkg::*;
#(
  parameter int PRE_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [2:0]       sel,
  output logic [PRE_W-1:0] cnt,
  output logic             adv,
  output logic             upd_stb
);
  localparam logic [PRE_W-1:0] HALF = {1'b1, {(PRE_W-1){1'b0}}};
  localparam logic [PRE_W-1:0] TOP  = '1;

  assign adv = tick_en && (sel == MODE_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= HALF;
      upd_stb <= 1'b0;
    end else begin
      upd_stb <= 1'b0;
      if (sel == MODE_HOLD) begin
        cnt <= HALF;
      end else if (adv) begin
        cnt     <= cnt + 1'b1;
        upd_stb <= (cnt == TOP);
      end
    end
  end

  // R3
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> !upd_stb);
  // R10
  stb_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    upd_stb |-> $past(tick_en));
  // R4
  hold_half_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == MODE_HOLD) |=> (cnt == HALF && !upd_stb));
  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (sel != MODE_HOLD && sel != MODE_RUN) |=> ($stable(cnt) && !upd_stb));
endmodule

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
  import rtc_tickgen_pkg::*;
#(
  parameter int PRE_W  = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [PRE_W-1:0]  cnt,
  input  logic [RATE_W-1:0] rate,
  input  logic              stat_rd,
  output logic              pi_flag
);
  int               shift;
  logic [PRE_W-1:0] mask;
  logic             hit;

  always_comb begin
    shift = rate_shift(rate);
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < shift);
    hit = adv && (shift != 0) && ((cnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst) pi_flag <= 1'b0;
    else     pi_flag <= hit || (pi_flag && !stat_rd);
  end

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pi_flag && !stat_rd) |=> pi_flag);
  // R6
  rate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == '0 && !pi_flag) |=> !pi_flag);
  // R10
  flag_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !pi_flag) |=> !pi_flag);
endmodule

// File: rtl/rtc_tickgen.sv
module rtc_tickgen #(
  parameter int PRE_W  = 15,
  parameter int SEL_W  = 3,
  parameter int RATE_W = 4,
  localparam int CTRL_W = SEL_W + RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              stat_rd,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              upd_stb,
  output logic              pi_flag
);
  logic [SEL_W-1:0]  sel;
  logic [RATE_W-1:0] rate;
  logic [PRE_W-1:0]  cnt;
  logic              adv;

  rtc_ctrl_reg #(.SEL_W(SEL_W), .RATE_W(RATE_W)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .sel(sel), .rate(rate)
  );

  rtc_div_chain #(.PRE_W(PRE_W)) div_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .sel(sel),
    .cnt(cnt), .adv(adv), .upd_stb(upd_stb)
  );

  rtc_rate_gen #(.PRE_W(PRE_W), .RATE_W(RATE_W)) rate_i (
    .clk(clk), .rst(rst), .adv(adv), .cnt(cnt), .rate(rate),
    .stat_rd(stat_rd), .pi_flag(pi_flag)
  );

  assign ctrl_q = {sel, rate};
endmodule

// File: tb/rtc_tickgen_tb.sv
module rtc_tickgen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [6:0] wr_data = '0;
  logic       stat_rd = 1'b0;
  logic [6:0] ctrl_q;
  logic       upd_stb;
  logic       pi_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rtc_tickgen dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
    .wr_data(wr_data), .stat_rd(stat_rd), .ctrl_q(ctrl_q),
    .upd_stb(upd_stb), .pi_flag(pi_flag)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] mode, input logic [3:0] code);
    wr_en = 1'b1; wr_data = {mode, code};
    step();
    wr_en = 1'b0;
  endtask

  task automatic clear_flag();
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
  endtask

  // Counts falling edges until the chosen output is high; ticks every gap cycles.
  task automatic wait_evt(input bit use_flag, input int gap, output int n);
    n = 0;
    forever begin
      tick_en = ((n % gap) == 0);
      step();
      n++;
      if ((use_flag ? pi_flag : upd_stb) || n > 70000) break;
    end
    tick_en = 1'b1;
  endtask

  function automatic int period_of(input int code);
    if (code == 1) return 128;
    if (code == 2) return 256;
    return 1 << (code - 1);
  endfunction

  initial begin
    int n;
    repeat (3) step();
    check("R1 ctrl reset", ctrl_q, 7'h26);
    check("R1 strobe reset", upd_stb, 0);
    check("R1 flag reset", pi_flag, 0);
    rst = 1'b0;
    wait_evt(0, 1, n);
    check("R1 first strobe after reset", n, 16384);

    // R7 R8 sweep over every nonzero rate code
    for (int code = 1; code < 16; code++) begin
      wr(3'b111, 4'(code));
      check("R2 readback", ctrl_q, {3'b111, 4'(code)});
      clear_flag();
      check("R9 flag cleared", pi_flag, 0);
      wr(3'b010, 4'(code));
      wait_evt(1, 1, n);
      if (code < 3) check("R8 aliased period", n, period_of(code));
      else          check("R7 period", n, period_of(code));
    end

    // R4 R6 R3: hold, release with rate off, two strobes
    wr(3'b111, 4'd0);
    clear_flag();
    repeat (20) step();
    check("R4 no strobe in hold", upd_stb, 0);
    wr(3'b010, 4'd0);
    wait_evt(0, 1, n);
    check("R4 first strobe half second", n, 16384);
    check("R6 flag off at rate 0", pi_flag, 0);
    step();
    check("R3 strobe one cycle", upd_stb, 0);
    wait_evt(0, 1, n);
    check("R3 strobe period", n, 32767);
    check("R6 flag still off", pi_flag, 0);

    // R5 freeze and resume
    wr(3'b111, 4'd0);
    wr(3'b010, 4'd0);
    repeat (1000) step();
    wr(3'b011, 4'd0);
    check("R5 readback frozen mode", ctrl_q, 7'h30);
    n = 0;
    for (int i = 0; i < 500; i++) begin
      step();
      if (upd_stb) n++;
    end
    check("R5 no strobe while frozen", n, 0);
    wr(3'b010, 4'd0);
    wait_evt(0, 1, n);
    check("R5 resume keeps position", n, 16384 - 1001);

    // R9 clear on quiet edge, set wins on event edge
    wr(3'b111, 4'd3);
    clear_flag();
    wr(3'b010, 4'd3);
    wait_evt(1, 1, n);
    check("R7 fastest rate first event", n, 4);
    clear_flag();
    check("R9 read clears", pi_flag, 0);
    step(); step();
    clear_flag();
    check("R9 event beats read", pi_flag, 1);
    repeat (3) step();
    check("R9 flag sticky", pi_flag, 1);

    // R10 ticks every other cycle
    wr(3'b111, 4'd0);
    wr(3'b010, 4'd0);
    wait_evt(0, 2, n);
    check("R10 gated ticks", n, 32767);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule